// File: doc/BRIEF.md
# PCI Configuration Access Bridge

This block sits on a simple CPU-side register bus and turns register writes into configuration reads and writes on a simplified downstream configuration port. Software first programs a target register with bus, device, function and register-offset fields. It then optionally loads write data. Finally it writes a command word that carries a command code and active-low byte enables. That command write launches the downstream transaction. When the bus number is zero the bridge builds a Type 0 address with a one-hot device-select bit. Any other bus number gives a Type 1 address. Read data, or all ones after an abort, lands in a read-data register.

Errors are captured on both sides in sticky status registers that are cleared by writing ones. The downstream side records master and target aborts together with the transaction address. The CPU side records rejected or unmapped accesses together with the register offset. Each captured address is frozen while any bit of its status register is still set.

A separate local path reaches a small header store belonging to the bridge itself. A local command word selects the dword and the direction. A write to the local write-data register then applies byte-masked data, and a local read command loads the local read-data register. The downstream request uses valid/ready: once raised, `cfg_req_valid` and its payload hold until `cfg_req_ready` is seen. The response carries no back-pressure and is accepted only while a request is outstanding.

Top module: `cfg_access_bridge`

## Requirements
- R1: After reset every register reads zero, `cfg_req_valid` is low, and a local read of dword 0 returns the parameter `HDR_ID`.
- R2: Register offsets are: 0x00 local command, 0x04 local write data (reads 0), 0x08 local read data, 0x0C target, 0x10 command, 0x14 write data, 0x18 read data, 0x1C downstream error status, 0x20 downstream error address, 0x24 CPU error status, 0x28 CPU error address. A read of an offset that is not on this list returns 0.
- R3: Command bits [3:0] hold the code, 0xA for a read and 0xB for a write; bits [7:4] hold active-low byte enables. An accepted command write raises `cfg_req_valid` on the next cycle and holds it with a stable payload until `cfg_req_ready`.
- R4: Target bits are bus [23:16], device [15:11], function [10:8] and offset [7:2]. For bus 0 the address has the single bit 11+device set, plus the function in [10:8], the offset in [7:2], and [1:0]=00. A device above 20 on bus 0 is rejected.
- R5: For a bus other than 0 the address is {8'h00, bus, device, function, offset, 2'b01}.
- R6: The legal byte-enable values are 0x0, 0xE, 0xD, 0xB, 0x7, 0xC and 0x3. A command or local command with any other value is rejected, and no transaction starts.
- R7: Bit 31 of a command-register read is 1 from the accepted command until the response is taken. A command written while this bit is 1 is rejected.
- R8: A write transaction carries the write-data register and the command's byte enables. A read with response status 0 stores `cfg_rsp_rdata` in the read-data register.
- R9: Response status bit 0 (master abort) sets downstream error bit 0, and status bit 1 (target abort) sets bit 1. A read that ends with a non-zero status returns 0xFFFFFFFF.
- R10: An error address is captured only when its status register holds no bits after the same cycle's clear. Writing ones clears the matching status bits.
- R11: An access to an unmapped or misaligned offset, a bad command code, or any rejected command sets CPU error bit 0 and records the offset in 0x28.
- R12: The local command holds the dword index in [7:2], the direction in [16] (1 = write) and active-low byte enables in [23:20]. A write to 0x04 in write mode updates only the enabled bytes. It is ignored in read mode and for dword 0. A read-mode command loads 0x08 on the next cycle. An index of `HDR_WORDS` or more is rejected.
- R13: `bus_rvalid` pulses for one cycle, on the cycle after a read, together with `bus_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | CPU access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | CPU write data |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | 32 | Read data |
| cfg_req_valid | output | 1 | Downstream request valid |
| cfg_req_ready | input | 1 | Downstream request accepted |
| cfg_req_write | output | 1 | 1 = configuration write |
| cfg_req_addr | output | 32 | Type 0 / Type 1 configuration address |
| cfg_req_be_n | output | 4 | Active-low byte enables |
| cfg_req_wdata | output | 32 | Write data |
| cfg_rsp_valid | input | 1 | Response strobe |
| cfg_rsp_status | input | 2 | Bit 0 master abort, bit 1 target abort |
| cfg_rsp_rdata | input | 32 | Read data |

## Verification
The hardest situation to reach is a second error arriving while an earlier one is still pending, followed by a partial clear. The captured address must survive both of these events. The stimulus runs a master abort and then a target abort without any clear in between. It next clears only the target-abort bit, and checks that the first address is still held after each step. A command written while a request is stalled is reached by holding `cfg_req_ready` low across a readback of the busy bit.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;

  localparam logic [7:0] REG_LCL_CMD = 8'h00;
  localparam logic [7:0] REG_LCL_WD  = 8'h04;
  localparam logic [7:0] REG_LCL_RD  = 8'h08;
  localparam logic [7:0] REG_TGT     = 8'h0C;
  localparam logic [7:0] REG_CMD     = 8'h10;
  localparam logic [7:0] REG_WD      = 8'h14;
  localparam logic [7:0] REG_RD      = 8'h18;
  localparam logic [7:0] REG_DERR    = 8'h1C;
  localparam logic [7:0] REG_DERR_A  = 8'h20;
  localparam logic [7:0] REG_UERR    = 8'h24;
  localparam logic [7:0] REG_UERR_A  = 8'h28;

  localparam logic [3:0] CODE_CFG_RD = 4'hA;
  localparam logic [3:0] CODE_CFG_WR = 4'hB;

  typedef enum logic [1:0] {TX_IDLE, TX_REQ, TX_WAIT} tx_state_e;

  function automatic logic be_legal(input logic [3:0] be_n);
    case (be_n)
      4'h0, 4'hE, 4'hD, 4'hB, 4'h7, 4'hC, 4'h3: return 1'b1;
      default:                                  return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/cfgb_addr_gen.sv
module cfgb_addr_gen #(
  parameter int IDSEL_LSB = 11
) (
  input  logic [21:0] tgt,      // target register bits [23:2]
  output logic [31:0] dn_addr,
  output logic        dev_ok
);
  localparam int MAX_T0_DEV = 31 - IDSEL_LSB;

  logic [7:0] bus_num;
  logic [4:0] dev_num;
  logic [2:0] fn_num;
  logic [5:0] dw_off;

  assign bus_num = tgt[21:14];
  assign dev_num = tgt[13:9];
  assign fn_num  = tgt[8:6];
  assign dw_off  = tgt[5:0];

  always_comb begin
    if (bus_num == 8'd0) begin
      dn_addr = (32'd1 << (32'(IDSEL_LSB) + 32'(dev_num)))
              | {21'd0, fn_num, dw_off, 2'b00};
      dev_ok  = (32'(dev_num) <= 32'(MAX_T0_DEV));
    end else begin
      dn_addr = {8'h00, bus_num, dev_num, fn_num, dw_off, 2'b01};
      dev_ok  = 1'b1;
    end
  end
endmodule

// File: rtl/cfgb_txn_ctrl.sv
module cfgb_txn_ctrl
  import cfgb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        start_write,
  input  logic [31:0] start_addr,
  input  logic [3:0]  start_be_n,
  input  logic [31:0] start_wdata,
  output logic        req_valid,
  input  logic        req_ready,
  output logic        req_write,
  output logic [31:0] req_addr,
  output logic [3:0]  req_be_n,
  output logic [31:0] req_wdata,
  input  logic        rsp_valid,
  output logic        busy,
  output logic        done
);
  tx_state_e state_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= TX_IDLE;
      req_write <= 1'b0;
      req_addr  <= '0;
      req_be_n  <= '0;
      req_wdata <= '0;
    end else begin
      case (state_q)
        TX_IDLE: if (start) begin
          state_q   <= TX_REQ;
          req_write <= start_write;
          req_addr  <= start_addr;
          req_be_n  <= start_be_n;
          req_wdata <= start_wdata;
        end
        TX_REQ:  if (req_ready) state_q <= TX_WAIT;
        TX_WAIT: if (rsp_valid) state_q <= TX_IDLE;
        default: state_q <= TX_IDLE;
      endcase
    end
  end

  assign req_valid = (state_q == TX_REQ);
  assign busy      = (state_q != TX_IDLE);
  assign done      = (state_q == TX_WAIT) && rsp_valid;
endmodule

// File: rtl/cfgb_err_cap.sv
module cfgb_err_cap #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic [31:0]  set_addr,
  input  logic         clr_we,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] status,
  output logic [31:0]  addr
);
  logic [W-1:0] kept;

  assign kept = status & ~(clr_we ? clr_mask : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= '0;
      addr   <= '0;
    end else begin
      status <= kept | set;
      if ((|set) && (kept == '0)) addr <= set_addr;
    end
  end
endmodule

// File: rtl/cfgb_local_hdr.sv
module cfgb_local_hdr #(
  parameter int          WORDS  = 16,
  parameter logic [31:0] HDR_ID = 32'h0F1E_C0DE,
  localparam int         IDX_W  = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [3:0]       wr_be_n,
  input  logic [31:0]      wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [31:0]      rd_data
);
  logic [31:0] words [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    if (g == 0) begin : g_id
      assign words[g] = HDR_ID;
    end else begin : g_rw
      logic [31:0] w_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          w_q <= '0;
        end else if (wr_en && (wr_idx == IDX_W'(g))) begin
          for (int b = 0; b < 4; b++)
            if (!wr_be_n[b]) w_q[8*b +: 8] <= wr_data[8*b +: 8];
        end
      end
      assign words[g] = w_q;
    end
  end

  assign rd_data = words[rd_idx];
endmodule

// File: rtl/cfg_access_bridge.sv
module cfg_access_bridge
  import cfgb_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter int          IDSEL_LSB = 11,
  parameter int          HDR_WORDS = 16,
  parameter logic [31:0] HDR_ID    = 32'h0F1E_C0DE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic              bus_rvalid,
  output logic [31:0]       bus_rdata,
  output logic              cfg_req_valid,
  input  logic              cfg_req_ready,
  output logic              cfg_req_write,
  output logic [31:0]       cfg_req_addr,
  output logic [3:0]        cfg_req_be_n,
  output logic [31:0]       cfg_req_wdata,
  input  logic              cfg_rsp_valid,
  input  logic [1:0]        cfg_rsp_status,
  input  logic [31:0]       cfg_rsp_rdata
);
  localparam int IDX_W = $clog2(HDR_WORDS);
  localparam logic [ADDR_W-1:0] A_LCL_CMD = ADDR_W'(REG_LCL_CMD);
  localparam logic [ADDR_W-1:0] A_LCL_WD  = ADDR_W'(REG_LCL_WD);
  localparam logic [ADDR_W-1:0] A_LCL_RD  = ADDR_W'(REG_LCL_RD);
  localparam logic [ADDR_W-1:0] A_TGT     = ADDR_W'(REG_TGT);
  localparam logic [ADDR_W-1:0] A_CMD     = ADDR_W'(REG_CMD);
  localparam logic [ADDR_W-1:0] A_WD      = ADDR_W'(REG_WD);
  localparam logic [ADDR_W-1:0] A_RD      = ADDR_W'(REG_RD);
  localparam logic [ADDR_W-1:0] A_DERR    = ADDR_W'(REG_DERR);
  localparam logic [ADDR_W-1:0] A_DERR_A  = ADDR_W'(REG_DERR_A);
  localparam logic [ADDR_W-1:0] A_UERR    = ADDR_W'(REG_UERR);
  localparam logic [ADDR_W-1:0] A_UERR_A  = ADDR_W'(REG_UERR_A);

  // register state
  logic [31:0] lcl_cmd_q, lcl_rd_q, tgt_q, wd_q, rd_q;
  logic [7:0]  cmd_q;

  // access decode
  logic wr, rd, mapped;
  assign wr     = bus_sel && bus_we;
  assign rd     = bus_sel && !bus_we;
  assign mapped = (bus_addr[1:0] == 2'b00) && (bus_addr <= A_UERR_A);

  // configuration command checks
  logic [31:0] dn_addr;
  logic        dev_ok, code_ok, busy, done, cmd_wr, cmd_accept, cmd_reject;

  cfgb_addr_gen #(.IDSEL_LSB(IDSEL_LSB)) u_addr_gen (
    .tgt     (tgt_q[23:2]),
    .dn_addr (dn_addr),
    .dev_ok  (dev_ok)
  );

  assign code_ok    = (bus_wdata[3:0] == CODE_CFG_RD) || (bus_wdata[3:0] == CODE_CFG_WR);
  assign cmd_wr     = wr && (bus_addr == A_CMD);
  assign cmd_accept = cmd_wr && code_ok && be_legal(bus_wdata[7:4]) && dev_ok && !busy;
  assign cmd_reject = cmd_wr && !cmd_accept;

  cfgb_txn_ctrl u_txn (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (cmd_accept),
    .start_write (bus_wdata[3:0] == CODE_CFG_WR),
    .start_addr  (dn_addr),
    .start_be_n  (bus_wdata[7:4]),
    .start_wdata (wd_q),
    .req_valid   (cfg_req_valid),
    .req_ready   (cfg_req_ready),
    .req_write   (cfg_req_write),
    .req_addr    (cfg_req_addr),
    .req_be_n    (cfg_req_be_n),
    .req_wdata   (cfg_req_wdata),
    .rsp_valid   (cfg_rsp_valid),
    .busy        (busy),
    .done        (done)
  );

  // local header path
  logic             lcl_cmd_wr, lcl_ok, lcl_reject, lcl_rd_load, lcl_wr_en;
  logic [31:0]      hdr_rdata;

  assign lcl_cmd_wr  = wr && (bus_addr == A_LCL_CMD);
  assign lcl_ok      = be_legal(bus_wdata[23:20])
                    && ({26'd0, bus_wdata[7:2]} < 32'(HDR_WORDS));
  assign lcl_reject  = lcl_cmd_wr && !lcl_ok;
  assign lcl_rd_load = lcl_cmd_wr && lcl_ok && !bus_wdata[16];
  assign lcl_wr_en   = wr && (bus_addr == A_LCL_WD) && lcl_cmd_q[16];

  cfgb_local_hdr #(.WORDS(HDR_WORDS), .HDR_ID(HDR_ID)) u_hdr (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (lcl_wr_en),
    .wr_idx  (lcl_cmd_q[2 +: IDX_W]),
    .wr_be_n (lcl_cmd_q[23:20]),
    .wr_data (bus_wdata),
    .rd_idx  (bus_wdata[2 +: IDX_W]),
    .rd_data (hdr_rdata)
  );

  // error capture, one instance per bus side
  logic [1:0]  derr;
  logic [0:0]  uerr;
  logic [31:0] derr_a, uerr_a;
  logic        uerr_set;

  assign uerr_set = (bus_sel && !mapped) || cmd_reject || lcl_reject;

  cfgb_err_cap #(.W(2)) u_derr (
    .clk      (clk),
    .rst_n    (rst_n),
    .set      (done ? cfg_rsp_status : 2'b00),
    .set_addr (cfg_req_addr),
    .clr_we   (wr && (bus_addr == A_DERR)),
    .clr_mask (bus_wdata[1:0]),
    .status   (derr),
    .addr     (derr_a)
  );

  cfgb_err_cap #(.W(1)) u_uerr (
    .clk      (clk),
    .rst_n    (rst_n),
    .set      (uerr_set),
    .set_addr (32'(bus_addr)),
    .clr_we   (wr && (bus_addr == A_UERR)),
    .clr_mask (bus_wdata[0:0]),
    .status   (uerr),
    .addr     (uerr_a)
  );

  // register writes
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lcl_cmd_q <= '0;
      lcl_rd_q  <= '0;
      tgt_q     <= '0;
      wd_q      <= '0;
      rd_q      <= '0;
      cmd_q     <= '0;
    end else begin
      if (lcl_cmd_wr && lcl_ok)              lcl_cmd_q <= bus_wdata;
      if (lcl_rd_load)                       lcl_rd_q  <= hdr_rdata;
      if (wr && (bus_addr == A_TGT))         tgt_q     <= bus_wdata;
      if (wr && (bus_addr == A_WD))          wd_q      <= bus_wdata;
      if (cmd_accept)                        cmd_q     <= bus_wdata[7:0];
      if (done && !cfg_req_write)
        rd_q <= (cfg_rsp_status == 2'b00) ? cfg_rsp_rdata : 32'hFFFF_FFFF;
    end
  end

  // read path
  logic [31:0] rmux;
  always_comb begin
    rmux = '0;
    case (bus_addr)
      A_LCL_CMD: rmux = lcl_cmd_q;
      A_LCL_WD:  rmux = '0;
      A_LCL_RD:  rmux = lcl_rd_q;
      A_TGT:     rmux = tgt_q;
      A_CMD:     rmux = {busy, 23'd0, cmd_q};
      A_WD:      rmux = wd_q;
      A_RD:      rmux = rd_q;
      A_DERR:    rmux = {30'd0, derr};
      A_DERR_A:  rmux = derr_a;
      A_UERR:    rmux = {31'd0, uerr};
      A_UERR_A:  rmux = uerr_a;
      default:   rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= rd;
      if (rd) bus_rdata <= rmux;
    end
  end
endmodule

// File: rtl/cfg_access_bridge_chk.sv
module cfg_access_bridge_chk
  import cfgb_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int IDSEL_LSB = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rvalid,
  input logic              cfg_req_valid,
  input logic              cfg_req_ready,
  input logic              cfg_req_write,
  input logic [31:0]       cfg_req_addr,
  input logic [3:0]        cfg_req_be_n
);
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid && !cfg_req_ready |=> cfg_req_valid && $stable(cfg_req_addr)
      && $stable(cfg_req_be_n) && $stable(cfg_req_write));

  p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_req_valid) |-> $past(bus_sel && bus_we && (bus_addr == ADDR_W'(REG_CMD))));

  p_legal_be_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid |-> be_legal(cfg_req_be_n));

  p_type0_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid && !cfg_req_addr[0] |->
      $onehot(cfg_req_addr[31:IDSEL_LSB]) && !cfg_req_addr[1]);

  p_type1_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid && cfg_req_addr[0] |-> (cfg_req_addr[31:24] == 8'h00) && !cfg_req_addr[1]);

  p_rvalid_r13: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> $past(bus_sel && !bus_we));
endmodule

bind cfg_access_bridge cfg_access_bridge_chk #(.ADDR_W(ADDR_W), .IDSEL_LSB(IDSEL_LSB)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_sel       (bus_sel),
  .bus_we        (bus_we),
  .bus_addr      (bus_addr),
  .bus_rvalid    (bus_rvalid),
  .cfg_req_valid (cfg_req_valid),
  .cfg_req_ready (cfg_req_ready),
  .cfg_req_write (cfg_req_write),
  .cfg_req_addr  (cfg_req_addr),
  .cfg_req_be_n  (cfg_req_be_n)
);

// File: tb/cfg_access_bridge_tb.sv
module cfg_access_bridge_tb;
  localparam logic [31:0] ID = 32'h0F1E_C0DE;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rvalid;
  logic [31:0] bus_rdata;
  logic        cfg_req_valid, cfg_req_write;
  logic        cfg_req_ready = 1'b0;
  logic [31:0] cfg_req_addr, cfg_req_wdata;
  logic [3:0]  cfg_req_be_n;
  logic        cfg_rsp_valid = 1'b0;
  logic [1:0]  cfg_rsp_status = '0;
  logic [31:0] cfg_rsp_rdata = '0;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  cfg_access_bridge #(.HDR_ID(ID)) u_dut (.*);

  typedef struct packed {
    logic [31:0] tgt;
    logic [7:0]  cmd;
    logic [31:0] exp_addr;
    logic [1:0]  st;
    logic [31:0] data;     // write data or response data
    logic [31:0] exp_rd;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{32'h0000_0000, 8'h0A, 32'h0000_0800, 2'd0, 32'h1234_5678, 32'h1234_5678},
    '{32'h0000_2A3C, 8'hEB, 32'h0001_023C, 2'd0, 32'h0000_00AB, 32'h0},
    '{32'h0003_3910, 8'hCA, 32'h0003_3911, 2'd1, 32'h5555_5555, 32'hFFFF_FFFF},
    '{32'h00FF_FFFE, 8'h3B, 32'h00FF_FFFD, 2'd2, 32'h0000_BEEF, 32'h0},
    '{32'h0000_A704, 8'h7A, 32'h8000_0704, 2'd0, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
    '{32'h0001_0008, 8'h0B, 32'h0001_0009, 2'd0, 32'hA5A5_0F0F, 32'h0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic expect_rd(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    bus_rd(a, d);
    check(req, d, exp);
  endtask

  // launch, handshake and answer one transaction
  task automatic run_txn(input string req, input logic [31:0] tgt, input logic [7:0] cmd,
                         input logic [31:0] data, input logic [1:0] st,
                         input logic [31:0] exp_addr);
    bus_wr(8'h0C, tgt);
    bus_wr(8'h14, data);
    bus_wr(8'h10, {24'd0, cmd});
    check({req, " R3 valid"}, 32'(cfg_req_valid), 32'd1);
    check({req, " addr"}, cfg_req_addr, exp_addr);
    check({req, " R3 be"}, 32'(cfg_req_be_n), 32'(cmd[7:4]));
    check({req, " R3 dir"}, 32'(cfg_req_write), 32'(cmd[0]));
    if (cmd[0]) check({req, " R8 wdata"}, cfg_req_wdata, data);
    @(negedge clk);
    check({req, " R3 hold"}, 32'(cfg_req_valid), 32'd1);
    cfg_req_ready = 1'b1;
    @(negedge clk);
    cfg_req_ready = 1'b0;
    cfg_rsp_valid = 1'b1; cfg_rsp_status = st; cfg_rsp_rdata = data;
    @(negedge clk);
    cfg_rsp_valid = 1'b0; cfg_rsp_status = 2'd0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state and R13 read strobe timing
    check("R1 req_valid", 32'(cfg_req_valid), 32'd0);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 8'h10;
    @(negedge clk);
    bus_sel = 1'b0;
    check("R13 rvalid", 32'(bus_rvalid), 32'd1);
    check("R1 cmd reg", bus_rdata, 32'd0);
    @(negedge clk);
    check("R13 rvalid one cycle", 32'(bus_rvalid), 32'd0);
    for (int a = 0; a <= 'h28; a += 4) begin
      if (a != 'h08) expect_rd("R1 R2 reset reg", 8'(a), 32'd0);
    end
    bus_wr(8'h00, 32'h0);
    expect_rd("R1 R12 header id", 8'h08, ID);

    // table of transactions
    foreach (VECS[i]) begin
      run_txn(VECS[i].exp_addr[0] ? "R5 vec" : "R4 vec", VECS[i].tgt, VECS[i].cmd,
              VECS[i].data, VECS[i].st, VECS[i].exp_addr);
      expect_rd("R9 derr status", 8'h1C, 32'(VECS[i].st));
      if (VECS[i].st != 2'd0) expect_rd("R9 derr addr", 8'h20, VECS[i].exp_addr);
      if (!VECS[i].cmd[0]) expect_rd("R8 R9 read data", 8'h18, VECS[i].exp_rd);
      bus_wr(8'h1C, 32'h3);
    end
    expect_rd("R10 cleared", 8'h1C, 32'd0);

    // R7 busy and command while busy
    bus_wr(8'h0C, 32'h0000_0800);
    bus_wr(8'h10, 32'h0A);
    expect_rd("R7 busy set", 8'h10, 32'h8000_000A);
    bus_wr(8'h10, 32'h0B);
    check("R7 reject keeps dir", 32'(cfg_req_write), 32'd0);
    expect_rd("R7 R11 cpu err", 8'h24, 32'd1);
    expect_rd("R11 cpu err addr", 8'h28, 32'h10);
    cfg_req_ready = 1'b1; @(negedge clk); cfg_req_ready = 1'b0;
    cfg_rsp_valid = 1'b1; cfg_rsp_rdata = 32'h0; @(negedge clk); cfg_rsp_valid = 1'b0;
    expect_rd("R7 busy clear", 8'h10, 32'h0000_000A);
    bus_wr(8'h24, 32'h1);
    expect_rd("R10 cpu clear", 8'h24, 32'd0);

    // R6 illegal byte enables, R11 bad code, R4 device range
    bus_wr(8'h0C, 32'h0);
    bus_wr(8'h10, 32'h5A);
    check("R6 no start", 32'(cfg_req_valid), 32'd0);
    expect_rd("R6 cpu err", 8'h24, 32'd1);
    bus_wr(8'h24, 32'h1);
    bus_wr(8'h10, 32'h02);
    check("R11 bad code no start", 32'(cfg_req_valid), 32'd0);
    expect_rd("R11 bad code err", 8'h24, 32'd1);
    bus_wr(8'h24, 32'h1);
    bus_wr(8'h0C, 32'h0000_A800);   // bus 0, device 21
    bus_wr(8'h10, 32'h0A);
    check("R4 dev21 no start", 32'(cfg_req_valid), 32'd0);
    expect_rd("R4 dev21 err", 8'h24, 32'd1);
    bus_wr(8'h24, 32'h1);

    // R11 unmapped and misaligned offsets
    expect_rd("R2 unmapped read", 8'h2C, 32'd0);
    expect_rd("R11 unmapped err addr", 8'h28, 32'h2C);
    bus_wr(8'h24, 32'h1);
    bus_wr(8'h05, 32'hFFFF_FFFF);
    expect_rd("R11 misaligned err addr", 8'h28, 32'h05);
    bus_wr(8'h24, 32'h1);

    // R10 address held across a second error and a partial clear
    run_txn("R4 hold a", 32'h0, 8'h0A, 32'h0, 2'd1, 32'h0000_0800);
    run_txn("R5 hold b", 32'h0001_0000, 8'h0A, 32'h0, 2'd2, 32'h0001_0001);
    expect_rd("R10 both bits", 8'h1C, 32'd3);
    expect_rd("R10 first addr kept", 8'h20, 32'h0000_0800);
    bus_wr(8'h1C, 32'h2);
    expect_rd("R10 partial clear", 8'h1C, 32'd1);
    expect_rd("R10 addr after partial", 8'h20, 32'h0000_0800);
    bus_wr(8'h1C, 32'h1);
    expect_rd("R10 all clear", 8'h1C, 32'd0);

    // R12 local header path
    bus_wr(8'h00, 32'h0001_000C);
    bus_wr(8'h04, 32'h1122_3344);
    bus_wr(8'h00, 32'h0000_000C);
    expect_rd("R12 full write", 8'h08, 32'h1122_3344);
    bus_wr(8'h00, 32'h00D1_000C);
    bus_wr(8'h04, 32'hAABB_CCDD);
    bus_wr(8'h00, 32'h0000_000C);
    expect_rd("R12 byte lane 1", 8'h08, 32'h1122_CC44);
    bus_wr(8'h04, 32'hFFFF_FFFF);
    bus_wr(8'h00, 32'h0000_000C);
    expect_rd("R12 read mode ignores", 8'h08, 32'h1122_CC44);
    bus_wr(8'h00, 32'h0001_0000);
    bus_wr(8'h04, 32'h0);
    bus_wr(8'h00, 32'h0);
    expect_rd("R12 word0 read-only", 8'h08, ID);
    bus_wr(8'h00, 32'h0001_0040);
    expect_rd("R12 index range kept", 8'h00, 32'h0);
    expect_rd("R12 R11 index err", 8'h24, 32'd1);
    bus_wr(8'h00, 32'h0051_0008);   // byte enables 0x5 are illegal
    expect_rd("R6 local be rejected", 8'h00, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule